// File: doc/BRIEF.md
# Open-Drain Two-Line Pin Control Register

This block is a single control word through which software bit-bangs a two-wire serial bus. The bus has a clock line and a data line. Each line gets one byte-wide lane of the word. A lane holds a direction bit, an output value bit, a pull-up-disable bit and a read-only sampled input bit. It also has two write-mask bits, which read back as 0.

A line set to input is released, and the external pull-up raises it. A line set to output drives its stored value, which software keeps at 0 for an open-drain low.

The direction field of a line changes only when its direction mask is 1 in the same write. The value field changes only when its value mask is 1. One write can therefore move one line, or both lines, without disturbing the other. Software does not need a read-modify-write for this. The pull-up-disable bit is loaded on every write, so software reads it back and writes it again unchanged.

Pad levels reach the readable input bits through a two-flop synchronizer.

Lane layout: line 0 (clock) uses word bits 7:0 and line 1 (data) uses bits 15:8. Within a lane, with b the lane base:

| Bit | Field |
|-----|-------|
| b+0 | direction mask |
| b+1 | direction (1 = output, 0 = input/released) |
| b+2 | value mask |
| b+3 | output value |
| b+4 | input level (read-only) |
| b+5 | pull-up disable |
| b+6, b+7 | unused, read as 0 |

Top module: `odpin_reg`

## Requirements
- R1: After reset both lines are released (`pad_oe`=0), the stored output values are 0, the pull-ups are enabled (`pu_dis`=0), and the input bits read the idle level 1. The reset read word is 16'h1010.
- R2: The direction bit (lane bit 1) of a line is loaded from the write only when the direction mask (lane bit 0) is 1 in that write. Otherwise it keeps its value.
- R3: The output value bit (lane bit 3) of a line is loaded only when the value mask (lane bit 2) is 1 in that write. Otherwise it keeps its value.
- R4: Writing direction 0 with the direction mask set releases the line: `pad_oe` for that line is 0 from the cycle after the write.
- R5: One write of direction 1, value 0 and both masks set drives the line low: `pad_oe`=1 and `pad_o`=0 from the cycle after the write.
- R6: A write whose masks for one lane are 0 leaves that line's pad outputs unchanged while the other line changes.
- R7: The input bit (lane bit 4) shows the level of `pad_i` after exactly two clock edges. After one edge it still shows the previous level.
- R8: The pull-up-disable bit (lane bit 5) is loaded from every write and drives `pu_dis` for that line.
- R9: `pad_oe` of a line is 1 only when its direction bit is 1, and `pad_o` always equals its stored value bit.
- R10: With `wr_en` low, nothing changes. Mask bits and unused bits always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| wr_en | input | 1 | write strobe for the control word |
| wr_data | input | 16 | write word, one lane per line |
| rd_data | output | 16 | read word, current fields and sampled inputs |
| pad_oe | output | 2 | pad output enable per line (bit 0 clock, bit 1 data) |
| pad_o | output | 2 | pad output value per line |
| pad_i | input | 2 | pad input level per line |
| pu_dis | output | 2 | pull-up disable per line |

## Verification
The masked update is tried with four kinds of write:
- Both masks set on a single line. This separates the drive-low and release paths.
- Exactly one mask set with conflicting field values. This shows that an unmasked field is really held.
- Masks set on one lane only. This shows the lanes are independent.
- An all-ones word. This separates loaded fields from bits that must read 0.

The input path is driven with a single level change sampled one and two edges later. This tells a correct two-stage delay from a one-stage or three-stage one. Pull-up-disable writes with masks clear show that this field follows every write, unlike the masked fields.

// File: rtl/odpin_pkg.sv
package odpin_pkg;

   // field positions inside one line lane
   localparam int FLD_DIR_MSK = 0;
   localparam int FLD_DIR     = 1;
   localparam int FLD_VAL_MSK = 2;
   localparam int FLD_VAL     = 3;
   localparam int FLD_IN      = 4;
   localparam int FLD_PUD     = 5;
   localparam int FLD_COUNT   = 6;

   typedef struct packed {
      logic pud;
      logic val;
      logic dir;
   } line_state_t;

endpackage

// File: rtl/odpin_sync.sv
module odpin_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("odpin_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/odpin_line.sv
module odpin_line
   import odpin_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [FLD_COUNT-1:0] fld,
   output line_state_t          st
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= '{pud: 1'b0, val: 1'b0, dir: 1'b0};
      end else if (wr_en) begin
         st.pud <= fld[FLD_PUD];
         if (fld[FLD_DIR_MSK]) st.dir <= fld[FLD_DIR];
         if (fld[FLD_VAL_MSK]) st.val <= fld[FLD_VAL];
      end
   end

endmodule

// File: rtl/odpin_reg.sv
module odpin_reg
   import odpin_pkg::*;
#(
   parameter int   NUM_LINES   = 2,
   parameter int   LANE_W      = 8,
   parameter int   SYNC_STAGES = 2,
   parameter logic IDLE_LEVEL  = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [NUM_LINES*LANE_W-1:0] wr_data,
   output logic [NUM_LINES*LANE_W-1:0] rd_data,
   output logic [NUM_LINES-1:0]        pad_oe,
   output logic [NUM_LINES-1:0]        pad_o,
   input  logic [NUM_LINES-1:0]        pad_i,
   output logic [NUM_LINES-1:0]        pu_dis
);

   localparam int WORD_W = NUM_LINES * LANE_W;

   generate
      if (LANE_W < FLD_COUNT) begin : g_bad_lane
         $error("odpin_reg lane too narrow for its fields");
      end
      if (NUM_LINES < 1) begin : g_bad_lines
         $error("odpin_reg needs at least one line");
      end
   endgenerate

   generate
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
         line_state_t       st;
         logic              in_s;
         logic [LANE_W-1:0] lane_rd;

         odpin_line i_line (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_en),
            .fld   (wr_data[i*LANE_W +: FLD_COUNT]),
            .st    (st)
         );

         odpin_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (IDLE_LEVEL)
         ) i_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (pad_i[i]),
            .q     (in_s)
         );

         always_comb begin
            lane_rd          = '0;
            lane_rd[FLD_DIR] = st.dir;
            lane_rd[FLD_VAL] = st.val;
            lane_rd[FLD_IN]  = in_s;
            lane_rd[FLD_PUD] = st.pud;
         end

         assign rd_data[i*LANE_W +: LANE_W] = lane_rd;
         assign pad_oe[i] = st.dir;
         assign pad_o[i]  = st.val;
         assign pu_dis[i] = st.pud;
      end
   endgenerate

endmodule

// File: rtl/odpin_chk.sv
module odpin_chk
   import odpin_pkg::*;
#(
   parameter int NUM_LINES   = 2,
   parameter int LANE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        wr_en,
   input logic [NUM_LINES*LANE_W-1:0] wr_data,
   input logic [NUM_LINES*LANE_W-1:0] rd_data,
   input logic [NUM_LINES-1:0]        pad_oe,
   input logic [NUM_LINES-1:0]        pad_o,
   input logic [NUM_LINES-1:0]        pad_i,
   input logic [NUM_LINES-1:0]        pu_dis
);

   logic [1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   generate
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
         localparam int B = i * LANE_W;

         p_oe_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
            pad_oe[i] == rd_data[B+FLD_DIR]);

         p_o_val_r9: assert property (@(posedge clk) disable iff (!rst_n)
            pad_o[i] == rd_data[B+FLD_VAL]);

         p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_data[B+FLD_DIR_MSK]) |=> (pad_oe[i] == $past(pad_oe[i])));

         p_dir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[B+FLD_DIR_MSK]) |=> (pad_oe[i] == $past(wr_data[B+FLD_DIR])));

         p_val_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_data[B+FLD_VAL_MSK]) |=> (pad_o[i] == $past(pad_o[i])));

         p_pud_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> (pu_dis[i] == $past(wr_data[B+FLD_PUD])));

         p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> ($stable(pad_oe[i]) && $stable(pad_o[i]) && $stable(pu_dis[i])));

         if (SYNC_STAGES == 2) begin : g_sync2
            p_sync_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
               (since_rst >= 2'd2) |-> (rd_data[B+FLD_IN] == $past(pad_i[i], 2)));
         end
      end
   endgenerate

endmodule

bind odpin_reg odpin_chk #(
   .NUM_LINES   (NUM_LINES),
   .LANE_W      (LANE_W),
   .SYNC_STAGES (SYNC_STAGES)
) i_odpin_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .rd_data (rd_data),
   .pad_oe  (pad_oe),
   .pad_o   (pad_o),
   .pad_i   (pad_i),
   .pu_dis  (pu_dis)
);

// File: tb/test_odpin_reg.sv
module test_odpin_reg;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic [1:0]  pad_oe, pad_o, pu_dis;
   logic [1:0]  pad_i = 2'b11;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   odpin_reg i_odpin_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .pad_oe  (pad_oe),
      .pad_o   (pad_o),
      .pad_i   (pad_i),
      .pu_dis  (pu_dis)
   );

   // lane: [0] dir mask, [1] dir, [2] val mask, [3] val, [5] pull-up disable
   function automatic logic [7:0] lane(input bit dm, input bit d, input bit vm,
                                       input bit v, input bit pud);
      return {2'b00, pud, 1'b0, v, vm, d, dm};
   endfunction

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic write_word(input logic [15:0] w);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = w;
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = '0;
   endtask

   task automatic t_reset;
      chk({14'd0, pad_oe}, 16'd0, "R1 pad_oe");
      chk({14'd0, pad_o},  16'd0, "R1 pad_o");
      chk({14'd0, pu_dis}, 16'd0, "R1 pu_dis");
      chk(rd_data, 16'h1010, "R1 read word");
   endtask

   task automatic t_drive_low;
      write_word({8'h00, lane(1, 1, 1, 0, 0)});
      chk({14'd0, pad_oe}, 16'd1, "R5 oe clock line low");
      chk({14'd0, pad_o},  16'd0, "R5 o clock line low");
      chk(rd_data, 16'h1012, "R5 read word");
   endtask

   task automatic t_masks;
      // value loaded with mask, direction bit 0 but mask clear: stays output
      write_word({8'h00, lane(0, 0, 1, 1, 0)});
      chk({14'd0, pad_o},  16'd1, "R3 value loaded with mask");
      chk({14'd0, pad_oe}, 16'd1, "R2 dir held without mask");
      // value 0 without mask: stays 1
      write_word({8'h00, lane(0, 1, 0, 0, 0)});
      chk({14'd0, pad_o}, 16'd1, "R3 value held without mask");
   endtask

   task automatic t_release;
      write_word({8'h00, lane(1, 0, 0, 0, 0)});
      chk({14'd0, pad_oe}, 16'd0, "R4 clock line released");
      chk({14'd0, pad_o},  16'd1, "R9 pad_o follows stored value");
   endtask

   task automatic t_independent;
      write_word({lane(1, 1, 1, 0, 0), 8'h00});
      chk({14'd0, pad_oe}, 16'd2, "R6 only data line driven");
      chk({14'd0, pad_o},  16'd1, "R6 clock value untouched");
      write_word({8'h00, lane(1, 1, 1, 0, 0)});
      chk({14'd0, pad_oe}, 16'd3, "R6 data line kept driven");
   endtask

   task automatic t_pullup;
      write_word({lane(0, 0, 0, 0, 1), 8'h00});
      chk({14'd0, pu_dis}, 16'd2, "R8 pull-up disable data");
      chk(rd_data & 16'h2020, 16'h2000, "R8 read back");
      write_word(16'h0000);
      chk({14'd0, pu_dis}, 16'd0, "R8 cleared by next write");
      chk({14'd0, pad_oe}, 16'd3, "R2 masks clear keep dir");
   endtask

   task automatic t_sync;
      @(negedge clk);
      pad_i = 2'b01;
      @(negedge clk);
      chk(rd_data & 16'h1010, 16'h1010, "R7 one edge old level");
      @(negedge clk);
      chk(rd_data & 16'h1010, 16'h0010, "R7 two edges new level");
      pad_i = 2'b11;
      @(negedge clk);
      @(negedge clk);
      chk(rd_data & 16'h1010, 16'h1010, "R7 restored level");
   endtask

   task automatic t_idle;
      logic [1:0] oe0, o0;
      oe0 = pad_oe;
      o0  = pad_o;
      @(negedge clk);
      wr_data = 16'hFFFF;
      repeat (3) @(negedge clk);
      chk({14'd0, pad_oe}, {14'd0, oe0}, "R10 no write oe");
      chk({14'd0, pad_o},  {14'd0, o0},  "R10 no write o");
      wr_data = '0;
   endtask

   task automatic t_all_ones;
      write_word(16'hFFFF);
      chk(rd_data, 16'h3A3A, "R10 masks and unused read 0");
      chk({14'd0, pad_oe}, 16'd3, "R9 oe with dir output");
      chk({14'd0, pad_o},  16'd3, "R9 o equals value");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_drive_low();
      t_masks();
      t_release();
      t_independent();
      t_pullup();
      t_sync();
      t_idle();
      t_all_ones();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule